// File: doc/BRIEF.md
# Reloadable Periodic Interval Timer

This block generates a regular interrupt from a slow timebase. A 32768 Hz tick arrives as a one-cycle enable pulse on the system clock. Software writes a 24-bit reload value as two halfwords. On the next tick the down counter loads that value, and from then on it counts one step per tick. When the count runs out, the block sets a sticky status bit and reloads the counter in the same tick, so the interval stays exactly N ticks. To get an interrupt rate of F Hz, software writes N = 32768 / F. The fastest useful rate is 6553 Hz, which gives N = 5.

A reload value of zero parks the timer: the counter holds at zero and no expiry occurs. This is also the state after reset. The live count can be read back at any time. Software acknowledges an event by writing 1 to the status bit. A separate enable bit gates the status bit onto a level interrupt line.

Top module: `pit_timer`

## Requirements
- R1: After reset, the reload value, the count, the enable bit, the status bit and `irq_o` are all zero.
- R2: The reload value is written at offset 0x10 (bits 15:0) and offset 0x12 (bits 23:16, taken from write-data bits 7:0). Both read back. Bits 15:8 at offset 0x12 always read zero.
- R3: A write to either reload halfword makes the first tick after the write cycle load the count with the reload value then held. A tick in the write cycle itself is processed with the old state.
- R4: Each tick that is not a pending load decrements the count by one. A tick that finds the count at 1 is an expiry: the count takes the reload value, so expiries are exactly N ticks apart.
- R5: While the reload value is zero, a tick forces the count to zero, and no expiry occurs.
- R6: Offset 0x1E bit 1 is the status bit, and the other bits of 0x1E read zero. An expiry sets the bit. Writing 1 to bit 1 clears it. Writing 0 to bit 1 leaves it unchanged.
- R7: If an expiry and a write of 1 to the status bit occur in the same cycle, the status bit ends up set.
- R8: Offset 0x1C bit 0 is the interrupt enable, and it reads back. `irq_o` is high exactly when both the status bit and the enable are set.
- R9: The count reads at offset 0x14 (bits 15:0) and offset 0x16 (bits 23:16, with bits 15:8 reading zero). The count does not change in a cycle without a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse at the 32768 Hz rate |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for `addr_i` (combinational) |
| irq_o | output | 1 | Level interrupt: status bit AND enable |

## Verification
Two pairs of events can land in the same clock cycle.

The first pair is an expiry and a host acknowledge. The bench steps the timer until its own model shows the count at 1. It then issues the tick and the write-1-to-clear of the status bit together, and expects the bit to read back set. A separate clear with no tick must then drop it.

The second pair is a reload write and a tick. Random traffic produces this case often. The bench model processes that tick with the old count and defers the load to the next tick, and every count and status read is compared with the model.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int ADDR_W = 5;
  localparam int HALF_W = 16;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 5'h10;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 5'h12;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 5'h14;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 5'h16;
  localparam logic [ADDR_W-1:0] A_CTRL   = 5'h1C;
  localparam logic [ADDR_W-1:0] A_STAT   = 5'h1E;
  localparam int STAT_BIT = 1;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int RELOAD_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [HALF_W-1:0]   wdata_i,
  input  logic [RELOAD_W-1:0] cnt_i,
  input  logic                flag_i,
  output logic [RELOAD_W-1:0] reload_o,
  output logic                reload_wr_o,
  output logic                en_o,
  output logic                clr_o,
  output logic [HALF_W-1:0]   rdata_o
);
  localparam int HI_W  = RELOAD_W - HALF_W;
  localparam int PAD_W = HALF_W - HI_W;

  logic [RELOAD_W-1:0] reload_q;
  logic                en_q;
  logic                wr_lo, wr_hi;

  assign wr_lo       = we_i && (addr_i == A_RLD_LO);
  assign wr_hi       = we_i && (addr_i == A_RLD_HI);
  assign reload_wr_o = wr_lo || wr_hi;
  assign clr_o       = we_i && (addr_i == A_STAT) && wdata_i[STAT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      en_q     <= 1'b0;
    end else begin
      if (wr_lo) reload_q[HALF_W-1:0] <= wdata_i;
      if (wr_hi) reload_q[RELOAD_W-1:HALF_W] <= wdata_i[HI_W-1:0];
      if (we_i && (addr_i == A_CTRL)) en_q <= wdata_i[0];
    end
  end

  assign reload_o = reload_q;
  assign en_o     = en_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_RLD_LO: rdata_o = reload_q[HALF_W-1:0];
      A_RLD_HI: rdata_o = {{PAD_W{1'b0}}, reload_q[RELOAD_W-1:HALF_W]};
      A_CNT_LO: rdata_o = cnt_i[HALF_W-1:0];
      A_CNT_HI: rdata_o = {{PAD_W{1'b0}}, cnt_i[RELOAD_W-1:HALF_W]};
      A_CTRL:   rdata_o = {{(HALF_W-1){1'b0}}, en_q};
      A_STAT:   rdata_o = {{(HALF_W-2){1'b0}}, flag_i, 1'b0};
      default:  rdata_o = '0;
    endcase
  end

  // R2: upper bits of the high halfword stay zero
  a_r2_hi_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_RLD_HI) |-> (rdata_o[HALF_W-1:HI_W] == '0));
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int RELOAD_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                reload_wr_i,
  output logic [RELOAD_W-1:0] cnt_o,
  output logic                expire_o
);
  localparam logic [RELOAD_W-1:0] ONE = RELOAD_W'(1);

  logic [RELOAD_W-1:0] cnt_q;
  logic                pend_q;
  logic                run;

  assign run      = (reload_i != '0) && !pend_q;
  assign expire_o = tick_i && run && (cnt_q <= ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (tick_i) begin
        if (pend_q)               cnt_q <= reload_i;
        else if (reload_i == '0)  cnt_q <= '0;
        else if (cnt_q <= ONE)    cnt_q <= reload_i;
        else                      cnt_q <= cnt_q - ONE;
      end
      pend_q <= (pend_q && !tick_i) || reload_wr_i;
    end
  end

  assign cnt_o = cnt_q;

  a_r4_expire_reloads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == $past(reload_i)));
  a_r4_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (cnt_q != '0) && (cnt_q <= reload_i));
  a_r5_zero_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !pend_q && (reload_i == '0)) |=> (cnt_q == '0));
  a_r9_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/pit_status.sv
module pit_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // set has priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (expire_i) flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && en_i;

  a_r6_set_on_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> flag_q);
  a_r6_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !expire_i) |=> !flag_q);
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  a_r8_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en_i);
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int RELOAD_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [HALF_W-1:0]  wdata_i,
  output logic [HALF_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic [RELOAD_W-1:0] reload, cnt;
  logic reload_wr, en, clr, flag, expire;

  pit_regs #(.RELOAD_W(RELOAD_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .cnt_i(cnt), .flag_i(flag), .reload_o(reload),
    .reload_wr_o(reload_wr), .en_o(en), .clr_o(clr), .rdata_o(rdata_o)
  );

  pit_counter #(.RELOAD_W(RELOAD_W)) u_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .reload_i(reload),
    .reload_wr_i(reload_wr), .cnt_o(cnt), .expire_o(expire)
  );

  pit_status u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(expire), .clr_i(clr),
    .en_i(en), .flag_o(flag), .irq_o(irq_o)
  );

  // R7: expiry beats a same-cycle acknowledge
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && clr) |=> flag);
  a_r3_load_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_wr && !tick_i) |=> (tick_i |=> (cnt == $past(reload))));
endmodule

// File: tb/pit_timer_tb.sv
module pit_timer_tb;
  localparam logic [4:0] LO = 5'h10, HI = 5'h12, CLO = 5'h14, CHI = 5'h16,
                         CTL = 5'h1C, STA = 5'h1E;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int vectors = 0, errors = 0;

  logic [23:0] m_rld = '0, m_cnt = '0;
  bit m_pend = 0, m_flag = 0, m_en = 0;

  pit_timer u_dut (.clk_i, .rst_ni, .tick_i, .we_i, .addr_i, .wdata_i,
                   .rdata_o, .irq_o);

  always #4 clk_i = ~clk_i;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model(input bit we, input logic [4:0] a, input logic [15:0] d, input bit tk);
    logic [23:0] r0 = m_rld;
    bit ex = 0, wr = 0, clr = 0;
    if (tk) begin
      if (m_pend)          m_cnt = r0;
      else if (r0 == 0)    m_cnt = 0;
      else if (m_cnt <= 1) begin ex = 1; m_cnt = r0; end
      else                 m_cnt = m_cnt - 1;
    end
    if (we) case (a)
      LO:  begin m_rld[15:0]  = d;      wr = 1; end
      HI:  begin m_rld[23:16] = d[7:0]; wr = 1; end
      CTL: m_en = d[0];
      STA: clr = d[1];
      default: ;
    endcase
    m_pend = (m_pend && !tk) || wr;
    m_flag = ex || (m_flag && !clr);
  endtask

  function automatic logic [15:0] exp_rd(input logic [4:0] a);
    case (a)
      LO:  return m_rld[15:0];
      HI:  return {8'h00, m_rld[23:16]};
      CLO: return m_cnt[15:0];
      CHI: return {8'h00, m_cnt[23:16]};
      CTL: return {15'b0, m_en};
      STA: return {14'b0, m_flag, 1'b0};
      default: return 16'h0;
    endcase
  endfunction

  task automatic cyc(input bit we, input logic [4:0] a, input logic [15:0] d, input bit tk);
    @(negedge clk_i);
    we_i = we; addr_i = a; wdata_i = d; tick_i = tk;
    @(posedge clk_i);
    model(we, a, d, tk);
    #2;
    we_i = 0; tick_i = 0;
    chk({15'b0, irq_o}, {15'b0, m_flag && m_en}, "R8 irq");
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk_i);
    we_i = 0; tick_i = 0; addr_i = a;
    #1;
    chk(rdata_o, exp, tag);
  endtask

  task automatic rd_m(input logic [4:0] a, input string tag);
    rd(a, exp_rd(a), tag);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    rd(LO, 16'h0, "R1 reload lo"); rd(HI, 16'h0, "R1 reload hi");
    rd(CLO, 16'h0, "R1 cnt lo");   rd(STA, 16'h0, "R1 status");
    rd(CTL, 16'h0, "R1 enable");
    chk({15'b0, irq_o}, 16'h0, "R1 irq");

    // R2 high halfword padding
    cyc(1, HI, 16'hFFAB, 0);
    rd(HI, 16'h00AB, "R2 hi pad");
    cyc(1, LO, 16'h1234, 0);
    rd(LO, 16'h1234, "R2 lo");
    cyc(0, LO, 0, 1);
    rd(CHI, 16'h00AB, "R9 cnt hi"); rd(CLO, 16'h1234, "R3 load");
    // R9 no tick, no change
    repeat (5) cyc(0, LO, 0, 0);
    rd(CLO, 16'h1234, "R9 hold");

    // R4 exact period of 7
    cyc(1, HI, 16'h0, 0); cyc(1, LO, 16'd7, 0);
    cyc(0, LO, 0, 1);
    cyc(1, CTL, 16'h1, 0);
    repeat (6) cyc(0, LO, 0, 1);
    rd(STA, 16'h0, "R4 before expiry"); rd(CLO, 16'd1, "R4 count at one");
    cyc(0, LO, 0, 1);
    rd(STA, 16'h2, "R4 expiry"); rd(CLO, 16'd7, "R4 reload");
    chk({15'b0, irq_o}, 16'h1, "R8 irq on");
    // R6 write 0 no effect, write 1 clears
    cyc(1, STA, 16'hFFFD, 0);
    rd(STA, 16'h2, "R6 write zero");
    cyc(1, STA, 16'h0002, 0);
    rd(STA, 16'h0, "R6 w1c");

    // R7 expiry with simultaneous clear
    while (m_cnt != 1) cyc(0, LO, 0, 1);
    cyc(1, STA, 16'h2, 1);
    rd(STA, 16'h2, "R7 set wins");
    cyc(1, STA, 16'h2, 0);
    rd(STA, 16'h0, "R7 later clear");

    // R5 zero reload parks
    cyc(1, LO, 16'h0, 0); cyc(0, LO, 0, 1);
    repeat (40) cyc(0, LO, 0, 1);
    rd(CLO, 16'h0, "R5 cnt zero"); rd(STA, 16'h0, "R5 no expiry");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom % 16;
      bit tk = ($urandom % 2) == 1;
      case (op)
        0: cyc(1, LO, (($urandom % 8) == 0) ? 16'h0 : 16'(5 + $urandom % 30), tk);
        1: cyc(1, HI, (($urandom % 6) == 0) ? 16'(($urandom % 65536)) & 16'hFF03 : 16'h0, tk);
        2: cyc(1, CTL, 16'($urandom % 65536), tk);
        3: cyc(1, STA, 16'($urandom % 65536), tk);
        4: rd_m(CLO, "R4 rand cnt lo");
        5: rd_m(CHI, "R9 rand cnt hi");
        6: rd_m(STA, "R6 rand status");
        7: rd_m(($urandom % 2) ? LO : HI, "R2 rand reload");
        default: cyc(0, LO, 0, tk);
      endcase
    end
    rd_m(STA, "R6 final status"); rd_m(CLO, "R3 final count");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule